// File: doc/BRIEF.md
# Cache Line Burst Fill Controller

This block sits between a cache lookup stage and a synchronous 32-bit external bus. A lookup result arrives on a valid/ready request channel. The block decides whether the read becomes a multi-beat line fill or a single bus transfer, and then runs the bus cycles. A line holds four long words. Each beat that lands is written into the line together with its long-word valid bit.

The first beat always fetches the long word that the requester asked for. For an operand that crosses two entries, the requester presents the lower-addressed entry. The first beat is a demand beat: its data goes straight out on the response channel. The remaining beats are background fill. They write the cache only, and nothing from them reaches the consumer.

The request channel applies back-pressure through `req_ready`. It stays low while a fill runs and while a response waits to be taken. The response channel holds `rsp_valid`, `rsp_data` and `rsp_err` unchanged until `rsp_ready` is seen high at a clock edge.

Top module: `line_fill_ctrl`

## Requirements
- R1: A burst request (`burst_req`) is raised only when the enable pair for the request type is fully set. For an instruction read the pair is `icache_en` and `iburst_en`; for a data read it is `dcache_en` and `dburst_en`. In every other case the read is a single transfer.
- R2: With R1 met, a burst is requested when the tag misses (`req_tag_hit`=0). It is also requested on a tag hit whose four `req_line_valid` bits are all 0. A tag hit with any valid bit set gives a single transfer.
- R3: A burst goes past the first beat only when `bus_burst_ack` and `bus_sync_done` are both high at the end of that beat. If the beat ends through `bus_async_done`, the acknowledge is ignored and the access finishes after that one beat.
- R4: A fill runs at most four beats. `bus_addr[ADDR_W-1:4]` stays equal to the request address for the whole fill, and `bus_addr[1:0]` is 0. `bus_addr[3:2]` starts at `req_addr[3:2]` and goes up by one per beat, wrapping modulo four (for example 2, 3, 0, 1).
- R5: The data and error of the first beat appear on `rsp_data`/`rsp_err` with `rsp_valid`=1 in the cycle after that beat ends. They stay unchanged until `rsp_ready` is taken, and later beats never change them. `req_ready` is 0 while `bus_req` is 1 or `rsp_valid` is 1.
- R6: A beat ended with `bus_inhibit`=1 (and no error) writes nothing into the line. It also ends the fill.
- R7: A beat ended with `bus_err`=1 writes its entry with `line_wr_valid`=0 (when the cache is on) and ends the fill. `rsp_err` is 1 only if that beat was the first beat; an error on a fill-only beat raises no fault.
- R8: On a tag miss with the cache on, `tag_wr` is 1 during the accept cycle. Each good beat then drives `line_wr_en`=1 and `line_wr_valid`=1, with `line_wr_idx` set to the beat's long-word index and `line_wr_data` set to `bus_rdata`.
- R9: With the cache enable for the request type at 0, the access is one transfer, `tag_wr` stays 0 and `line_wr_en` stays 0.
- R10: Out of reset, `bus_req`, `burst_req` and `rsp_valid` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| icache_en | input | 1 | Instruction cache enable |
| iburst_en | input | 1 | Instruction burst-fill enable |
| dcache_en | input | 1 | Data cache enable |
| dburst_en | input | 1 | Data burst-fill enable |
| req_valid | input | 1 | Read miss/lookup request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ADDR_W | Byte address of requested long word |
| req_is_insn | input | 1 | 1 = instruction read, 0 = data read |
| req_tag_hit | input | 1 | Indexed tag matched |
| req_line_valid | input | WORDS | Current long-word valid bits of the line |
| tag_wr | output | 1 | Write new tag and clear line valid bits |
| bus_req | output | 1 | Bus cycle in progress |
| bus_addr | output | ADDR_W | Bus address of current beat |
| burst_req | output | 1 | Burst request, first beat only |
| bus_sync_done | input | 1 | Synchronous termination |
| bus_async_done | input | 1 | Asynchronous termination |
| bus_burst_ack | input | 1 | Burst acknowledge |
| bus_inhibit | input | 1 | Beat data not cacheable |
| bus_err | input | 1 | Bus error termination |
| bus_rdata | input | DATA_W | Bus read data |
| line_wr_en | output | 1 | Write one long word of the line |
| line_wr_idx | output | IDX_W | Long-word index in line |
| line_wr_valid | output | 1 | Valid bit value written |
| line_wr_data | output | DATA_W | Long-word data written |
| rsp_valid | output | 1 | Demand response valid |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_data | output | DATA_W | Demand long word |
| rsp_err | output | 1 | Demand beat ended in bus error |

## Verification
The assertions are evaluated on every cycle. They check that a fill never runs past four beats and that the upper address bits stay fixed while the bus is busy. They check that `burst_req` appears only on the first beat, and that asynchronous, inhibited and error terminations each end the bus activity. They also check that an inhibited beat writes nothing, that an error beat writes its entry as invalid, and that a waiting response holds still.

Only the bench scenarios can show the behaviour that depends on the request: the enable-pair and all-invalid-hit decisions, the exact wrap order of the indices, the demand data matching beat zero, and the fault being raised only for a demand-beat error.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BEAT = 1'b1
  } fill_st_e;
endpackage

// File: rtl/lfc_trigger.sv
module lfc_trigger #(
  parameter int WORDS = 4
) (
  input  logic             is_insn,
  input  logic             tag_hit,
  input  logic [WORDS-1:0] line_valid,
  input  logic             icache_en,
  input  logic             iburst_en,
  input  logic             dcache_en,
  input  logic             dburst_en,
  output logic             cache_on,
  output logic             burst_want
);
  logic burst_on;
  logic line_empty;

  always_comb begin
    cache_on   = is_insn ? icache_en : dcache_en;
    burst_on   = is_insn ? iburst_en : dburst_en;
    line_empty = ~|line_valid;
    burst_want = cache_on & burst_on & (~tag_hit | line_empty);
  end
endmodule

// File: rtl/lfc_beat_seq.sv
module lfc_beat_seq
  import lfc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        start_addr,
  input  logic                     burst_want,
  input  logic                     cache_on,
  input  logic                     sync_done,
  input  logic                     async_done,
  input  logic                     burst_ack,
  input  logic                     inhibit,
  input  logic                     bus_err,
  output logic                     busy,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic                     burst_req,
  output logic                     first_beat,
  output logic                     fill_cache,
  output logic [$clog2(WORDS)-1:0] idx,
  output logic                     beat_end,
  output logic                     beat_ok,
  output logic                     beat_err
);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int BASE_W = ADDR_W - IDX_W - 2;
  localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(WORDS - 1);

  fill_st_e          state;
  logic [BASE_W-1:0] base;
  logic [IDX_W-1:0]  cnt;
  logic              first;
  logic              burst_go;
  logic              cont;

  always_comb begin
    busy       = (state == ST_BEAT);
    first_beat = busy & first;
    burst_req  = first_beat & burst_go;
    bus_addr   = busy ? {base, idx, 2'b00} : '0;
    beat_end   = busy & (sync_done | async_done | bus_err);
    beat_err   = busy & bus_err;
    beat_ok    = beat_end & ~bus_err & ~inhibit;
    cont       = beat_ok & sync_done &
                 (first ? (burst_go & burst_ack) : (cnt != LAST_CNT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      base       <= '0;
      idx        <= '0;
      cnt        <= '0;
      first      <= 1'b0;
      burst_go   <= 1'b0;
      fill_cache <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        state      <= ST_BEAT;
        base       <= start_addr[ADDR_W-1:IDX_W+2];
        idx        <= start_addr[IDX_W+1:2];
        cnt        <= '0;
        first      <= 1'b1;
        burst_go   <= burst_want;
        fill_cache <= cache_on;
      end
    end else if (beat_end) begin
      if (cont) begin
        idx   <= idx + 1'b1;
        cnt   <= cnt + 1'b1;
        first <= 1'b0;
      end else begin
        state <= ST_IDLE;
        first <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lfc_resp.sv
module lfc_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_err,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_data;
      rsp_err   <= load_err;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/line_fill_ctrl.sv
module line_fill_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              icache_en,
  input  logic              iburst_en,
  input  logic              dcache_en,
  input  logic              dburst_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_insn,
  input  logic              req_tag_hit,
  input  logic [WORDS-1:0]  req_line_valid,
  output logic              tag_wr,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              burst_req,
  input  logic              bus_sync_done,
  input  logic              bus_async_done,
  input  logic              bus_burst_ack,
  input  logic              bus_inhibit,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              line_wr_en,
  output logic [IDX_W-1:0]  line_wr_idx,
  output logic              line_wr_valid,
  output logic [DATA_W-1:0] line_wr_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);
  logic             cache_on;
  logic             burst_want;
  logic             accept;
  logic             busy;
  logic             first_beat;
  logic             fill_cache;
  logic [IDX_W-1:0] idx;
  logic             beat_end;
  logic             beat_ok;
  logic             beat_err;

  lfc_trigger #(.WORDS(WORDS)) i_trigger (
    .is_insn    (req_is_insn),
    .tag_hit    (req_tag_hit),
    .line_valid (req_line_valid),
    .icache_en  (icache_en),
    .iburst_en  (iburst_en),
    .dcache_en  (dcache_en),
    .dburst_en  (dburst_en),
    .cache_on   (cache_on),
    .burst_want (burst_want)
  );

  always_comb begin
    req_ready = ~busy & ~rsp_valid;
    accept    = req_valid & req_ready;
    tag_wr    = accept & cache_on & ~req_tag_hit;
  end

  lfc_beat_seq #(.ADDR_W(ADDR_W), .WORDS(WORDS)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_addr (req_addr),
    .burst_want (burst_want),
    .cache_on   (cache_on),
    .sync_done  (bus_sync_done),
    .async_done (bus_async_done),
    .burst_ack  (bus_burst_ack),
    .inhibit    (bus_inhibit),
    .bus_err    (bus_err),
    .busy       (busy),
    .bus_addr   (bus_addr),
    .burst_req  (burst_req),
    .first_beat (first_beat),
    .fill_cache (fill_cache),
    .idx        (idx),
    .beat_end   (beat_end),
    .beat_ok    (beat_ok),
    .beat_err   (beat_err)
  );

  always_comb begin
    bus_req       = busy;
    line_wr_en    = fill_cache & (beat_ok | beat_err);
    line_wr_idx   = idx;
    line_wr_valid = ~beat_err;
    line_wr_data  = bus_rdata;
  end

  lfc_resp #(.DATA_W(DATA_W)) i_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (first_beat & beat_end),
    .load_data (bus_rdata),
    .load_err  (beat_err),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err)
  );
endmodule

// File: rtl/lfc_checker.sv
module lfc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              burst_req,
  input logic              bus_sync_done,
  input logic              bus_async_done,
  input logic              bus_inhibit,
  input logic              bus_err,
  input logic              line_wr_en,
  input logic              line_wr_valid,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data
);
  logic [2:0] beats_seen;
  logic       end_obs;

  assign end_obs = bus_req & (bus_sync_done | bus_async_done | bus_err);

  always_ff @(posedge clk) begin
    if (!rst_n || !bus_req) beats_seen <= '0;
    else if (end_obs && beats_seen != 3'd7) beats_seen <= beats_seen + 3'd1;
  end

  a_r4_max_beats: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> beats_seen < 3'd4);
  a_r4_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && $past(bus_req) |-> bus_addr[ADDR_W-1:4] == $past(bus_addr[ADDR_W-1:4]));
  a_r1_burst_first_only: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |-> bus_req && beats_seen == 3'd0);
  a_r3_async_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_async_done |=> !bus_req);
  a_r6_inhibit_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_inhibit && !bus_err |-> !line_wr_en);
  a_r6_inhibit_ends: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_inhibit && bus_sync_done |=> !bus_req);
  a_r7_err_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_err && line_wr_en |-> !line_wr_valid);
  a_r7_err_ends: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_err |=> !bus_req);
  a_r5_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  a_r5_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req || rsp_valid) |-> !req_ready);
endmodule

bind line_fill_ctrl lfc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_ready      (req_ready),
  .bus_req        (bus_req),
  .bus_addr       (bus_addr),
  .burst_req      (burst_req),
  .bus_sync_done  (bus_sync_done),
  .bus_async_done (bus_async_done),
  .bus_inhibit    (bus_inhibit),
  .bus_err        (bus_err),
  .line_wr_en     (line_wr_en),
  .line_wr_valid  (line_wr_valid),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_data       (rsp_data)
);

// File: tb/test_line_fill_ctrl.sv
module test_line_fill_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        icache_en = 0, iburst_en = 0, dcache_en = 0, dburst_en = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_is_insn = 0, req_tag_hit = 0;
  logic [3:0]  req_line_valid = '0;
  logic        tag_wr, bus_req, burst_req;
  logic [31:0] bus_addr;
  logic        bus_sync_done = 0, bus_async_done = 0, bus_burst_ack = 0;
  logic        bus_inhibit = 0, bus_err = 0;
  logic [31:0] bus_rdata = '0;
  logic        line_wr_en, line_wr_valid;
  logic [1:0]  line_wr_idx;
  logic [31:0] line_wr_data;
  logic        rsp_valid, rsp_err;
  logic        rsp_ready = 0;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  line_fill_ctrl i_line_fill_ctrl (.*);

  localparam logic [1:0] K_INH = 2'd0, K_ERR = 2'd1, K_ASY = 2'd2, K_OK = 2'd3;

  typedef struct packed {
    logic       insn;
    logic       hit;
    logic [3:0] lv;
    logic [3:0] en;    // {icache, iburst, dcache, dburst}
    logic [1:0] idx;
    logic       ack;
    logic [2:0] stop;  // beat with special end, 4 = none
    logic [1:0] kind;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 4'h0, 4'b0011, 2'd2, 1'b1, 3'd4, K_OK},  // R2 R4 R8 data miss burst
    '{1'b1, 1'b0, 4'h0, 4'b1100, 2'd0, 1'b1, 3'd4, K_OK},  // R1 insn burst
    '{1'b0, 1'b0, 4'h0, 4'b0010, 2'd1, 1'b1, 3'd4, K_OK},  // R1 burst enable off
    '{1'b1, 1'b0, 4'h0, 4'b0111, 2'd3, 1'b1, 3'd4, K_OK},  // R9 insn cache off
    '{1'b0, 1'b1, 4'h0, 4'b0011, 2'd1, 1'b1, 3'd4, K_OK},  // R2 hit, all invalid
    '{1'b0, 1'b1, 4'h4, 4'b0011, 2'd1, 1'b1, 3'd4, K_OK},  // R2 hit, some valid
    '{1'b0, 1'b0, 4'h0, 4'b0011, 2'd0, 1'b0, 3'd4, K_OK},  // R3 no ack
    '{1'b0, 1'b0, 4'h0, 4'b0011, 2'd2, 1'b1, 3'd0, K_ASY}, // R3 ack on async ignored
    '{1'b0, 1'b0, 4'h0, 4'b0011, 2'd3, 1'b1, 3'd2, K_INH}, // R6 inhibit mid burst
    '{1'b1, 1'b0, 4'h0, 4'b1100, 2'd1, 1'b1, 3'd1, K_ERR}, // R7 fill-only error
    '{1'b0, 1'b0, 4'h0, 4'b0011, 2'd0, 1'b1, 3'd0, K_ERR}, // R7 demand error
    '{1'b0, 1'b0, 4'h0, 4'b0011, 2'd2, 1'b1, 3'd1, K_ASY}  // R3 async ends later beat
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_bus();
    bus_sync_done = 0; bus_async_done = 0; bus_burst_ack = 0;
    bus_inhibit = 0; bus_err = 0;
  endtask

  task automatic run_vec(input int v);
    vec_t        t;
    logic        cen, ben, bexp, cont, wr_exp;
    logic [1:0]  kind;
    logic [1:0]  wi;
    logic [31:0] addr, d0;
    t    = VECS[v];
    cen  = t.insn ? t.en[3] : t.en[1];
    ben  = t.insn ? t.en[2] : t.en[0];
    bexp = cen & ben & (~t.hit | (t.lv == 4'h0));
    addr = 32'h0001_2300 | (32'(v) << 12) | (32'(t.idx) << 2);
    d0   = 32'hC0DE_0000 | (32'(v) << 8);
    icache_en = t.en[3]; iburst_en = t.en[2]; dcache_en = t.en[1]; dburst_en = t.en[0];
    @(negedge clk);
    req_valid = 1; req_addr = addr; req_is_insn = t.insn;
    req_tag_hit = t.hit; req_line_valid = t.lv;
    #1;
    chk("R5 req_ready idle", 64'(req_ready), 64'd1);
    chk("R8 R9 tag_wr", 64'(tag_wr), 64'(cen & ~t.hit));
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 4; k++) begin
      kind = (k == int'(t.stop)) ? t.kind : K_OK;
      wi   = t.idx + 2'(k);
      bus_rdata = d0 | 32'(k);
      bus_burst_ack = t.ack;
      case (kind)
        K_OK:  bus_sync_done = 1;
        K_INH: begin bus_sync_done = 1; bus_inhibit = 1; end
        K_ERR: bus_err = 1;
        default: bus_async_done = 1;
      endcase
      #1;
      chk("R4 bus_req during beat", 64'(bus_req), 64'd1);
      chk("R4 beat address", 64'(bus_addr), 64'({addr[31:4], wi, 2'b00}));
      chk("R1 R2 burst_req", 64'(burst_req), 64'((k == 0) & bexp));
      chk("R5 req_ready busy", 64'(req_ready), 64'd0);
      wr_exp = cen & (kind != K_INH);
      chk("R6 R8 R9 line_wr_en", 64'(line_wr_en), 64'(wr_exp));
      if (wr_exp) begin
        chk("R7 R8 line_wr_valid", 64'(line_wr_valid), 64'(kind != K_ERR));
        chk("R8 line_wr_idx", 64'(line_wr_idx), 64'(wi));
        chk("R8 line_wr_data", 64'(line_wr_data), 64'(d0 | 32'(k)));
      end
      if (k > 0) begin
        chk("R5 demand word held", 64'({rsp_valid, rsp_data}), 64'({1'b1, d0}));
      end
      cont = (kind == K_OK) && ((k == 0) ? (bexp & t.ack) : (k < 3));
      @(negedge clk);
      clear_bus();
      if (!cont) break;
    end
    #1;
    chk("R3 R4 R6 R7 fill ended", 64'(bus_req), 64'd0);
    chk("R5 rsp_valid", 64'(rsp_valid), 64'd1);
    chk("R5 rsp_data", 64'(rsp_data), 64'(d0));
    chk("R7 rsp_err", 64'(rsp_err), 64'((t.stop == 3'd0) && (t.kind == K_ERR)));
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    #1;
    chk("R5 rsp taken", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 bus_req reset", 64'(bus_req), 64'd0);
    chk("R10 burst_req reset", 64'(burst_req), 64'd0);
    chk("R10 rsp_valid reset", 64'(rsp_valid), 64'd0);
    chk("R10 req_ready reset", 64'(req_ready), 64'd1);
    @(negedge clk);
    rst_n = 1;

    for (int v = 0; v < NV; v++) run_vec(v);

    // R5 back-pressure: held response blocks new requests
    icache_en = 0; iburst_en = 0; dcache_en = 1; dburst_en = 0;
    @(negedge clk);
    req_valid = 1; req_addr = 32'h0000_8004; req_is_insn = 0;
    req_tag_hit = 1; req_line_valid = 4'h2;
    @(negedge clk);
    req_valid = 0;
    bus_sync_done = 1; bus_rdata = 32'h1234_5678;
    @(negedge clk);
    clear_bus();
    bus_rdata = 32'hDEAD_BEEF;
    req_valid = 1; req_addr = 32'h0000_9000;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk("R5 back-pressure req_ready", 64'(req_ready), 64'd0);
      chk("R5 back-pressure no bus", 64'(bus_req), 64'd0);
      chk("R5 back-pressure data", 64'({rsp_valid, rsp_data}), 64'({1'b1, 32'h1234_5678}));
      @(negedge clk);
    end
    req_valid = 0;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    #1;
    chk("R5 released", 64'(req_ready), 64'd1);
    chk("R5 no stray bus cycle", 64'(bus_req), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule